// File: doc/BRIEF.md
# Serial Block DMA Channel

This block is one single-address DMA channel that moves a single block of bytes between a serial controller and system memory. The channel index parameter fixes its direction. An even channel takes bytes from the serial receiver and writes them to memory, starting at the programmed start address. An odd channel reads memory from the start address and hands the data to the serial transmitter. Software loads a 24-bit start address and a 16-bit byte count, then writes the control register with the go bit set. The channel then steps through the block. It uses 16-bit word accesses where it can and byte accesses where it must. When the count reaches zero it returns to idle and raises a sticky completion status.

The controller is a four-state machine:
- `ST_IDLE`: waits for go. Go with a nonzero count moves to `ST_WAIT_PEER`. Go with a zero count sets completion at once and stays in `ST_IDLE`.
- `ST_WAIT_PEER`: holds until the serial side signals readiness, then moves to `ST_BUS`.
- `ST_BUS`: holds the memory request until acknowledge. On acknowledge the address and count update. The machine moves to `ST_END` if that step emptied the count, and back to `ST_WAIT_PEER` if it did not.
- `ST_END`: sets completion and returns to `ST_IDLE`.

The interrupt line is completion gated by the interrupt-enable bit. Writing one to the status register clears completion.

Top module: `serdma_channel`

## Requirements
- R1: A write with `cfg_sel`=0 loads `cfg_wdata` as the start address, and a write with `cfg_sel`=1 loads `cfg_wdata[15:0]` as the byte count. Both writes are ignored while `busy` is high.
- R2: A write with `cfg_sel`=2 and bit 0 set starts a transfer when the count is nonzero. With a zero count it sets `done` immediately and makes no bus request.
- R3: An even `CHAN_IDX` issues memory writes (`mem_we`=1) carrying serial receive data. An odd `CHAN_IDX` issues memory reads (`mem_we`=0) whose data goes to the serial side. Both directions pulse `peer_strobe` in the cycle the access is acknowledged.
- R4: An access is a word (`mem_word`=1) only when the current address is even and at least 2 bytes remain. Otherwise it is a byte, so a remaining count of 1 always gives a byte.
- R5: After each acknowledged access, the address advances by 1 for a byte or 2 for a word, and the count drops by the same amount. The address wraps modulo 2^24.
- R6: Each step waits for `peer_ready` before raising `mem_req`. The request stays high, with address and width unchanged, until `mem_ack`.
- R7: When the count reaches zero the channel stops issuing accesses, drops `busy` and sets `done`.
- R8: `irq` equals `done` AND the interrupt enable, which is bit 1 of the last `cfg_sel`=2 write. Writing `cfg_sel`=3 with bit 0 set clears `done`.
- R9: Byte accesses carry data on bits [7:0] with bits [15:8] zero. Word accesses carry all 16 bits, in both the memory write data and the serial-side data.
- R10: A go write while `busy` is high has no effect on the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 control, 3 status |
| cfg_wdata | input | 24 | Register write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_word | output | 1 | 1 = 16-bit access, 0 = byte access |
| mem_addr | output | 24 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| mem_ack | input | 1 | Memory access acknowledge |
| peer_ready | input | 1 | Serial side has data (receive) or space (transmit) |
| peer_rdata | input | 16 | Data from the serial receiver |
| peer_wdata | output | 16 | Data to the serial transmitter |
| peer_strobe | output | 1 | Serial data consumed or delivered this cycle |
| xfer_word | output | 1 | Width of the pending step, 1 = word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sticky completion status |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds two channels with the default 24-bit address and 16-bit count, one with `CHAN_IDX`=0 and one with `CHAN_IDX`=1, so both directions are covered by a single build. It sweeps every start-address alignment from 0 to 3 against every count from 0 to 7, in both directions. That sweep reaches each mix of leading byte, word run and trailing byte, including the zero-count and single-byte cases. The bench also varies serial readiness and memory stall lengths. One run starts just below the top of the 24-bit address space to exercise address wrap, and another writes the registers in the middle of a transfer to show that such writes are ignored.

// File: rtl/serdma_pkg.sv
package serdma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_PEER,
        ST_BUS,
        ST_END
    } dma_state_e;

    localparam logic [1:0] SEL_ADDR  = 2'd0;
    localparam logic [1:0] SEL_COUNT = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;
    localparam logic [1:0] SEL_STAT  = 2'd3;

    localparam int CTRL_GO_BIT   = 0;
    localparam int CTRL_IE_BIT   = 1;
    localparam int STAT_DONE_BIT = 0;

endpackage

// File: rtl/serdma_counters.sv
module serdma_counters #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_addr,
    input  logic              load_cnt,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              step,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic              use_word,
    output logic              is_last,
    output logic              cnt_zero
);
    logic [CNT_W-1:0]  step_cnt;
    logic [ADDR_W-1:0] step_addr;

    // word only on even address with two or more bytes left
    always_comb begin
        use_word  = !cur_addr[0] && (cur_cnt[CNT_W-1:1] != '0);
        step_cnt  = use_word ? CNT_W'(2) : CNT_W'(1);
        step_addr = use_word ? ADDR_W'(2) : ADDR_W'(1);
        is_last   = (cur_cnt == step_cnt);
        cnt_zero  = (cur_cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
        end else if (load_addr) begin
            cur_addr <= wdata;
        end else if (step) begin
            cur_addr <= cur_addr + step_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_cnt <= '0;
        end else if (load_cnt) begin
            cur_cnt <= wdata[CNT_W-1:0];
        end else if (step) begin
            cur_cnt <= cur_cnt - step_cnt;
        end
    end
endmodule

// File: rtl/serdma_status.sv
module serdma_status
    import serdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [1:0] cfg_sel,
    input  logic [1:0] ctrl_bits,
    input  logic       busy,
    input  logic       done_set,
    output logic       go,
    output logic       irq_en,
    output logic       done,
    output logic       irq
);
    logic ctrl_wr;
    logic stat_clr;

    always_comb begin
        ctrl_wr  = cfg_we && (cfg_sel == SEL_CTRL);
        stat_clr = cfg_we && (cfg_sel == SEL_STAT) && ctrl_bits[STAT_DONE_BIT];
        go       = ctrl_wr && ctrl_bits[CTRL_GO_BIT] && !busy;
        irq      = done && irq_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en <= 1'b0;
        end else if (ctrl_wr) begin
            irq_en <= ctrl_bits[CTRL_IE_BIT];
        end
    end

    // completion set wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else if (done_set) begin
            done <= 1'b1;
        end else if (stat_clr) begin
            done <= 1'b0;
        end
    end
endmodule

// File: rtl/serdma_fsm.sv
module serdma_fsm
    import serdma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic cnt_zero,
    input  logic is_last,
    input  logic peer_ready,
    input  logic mem_ack,
    output logic mem_req,
    output logic step,
    output logic done_set,
    output logic busy
);
    dma_state_e state_q;
    dma_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go && !cnt_zero) begin
                    state_d = ST_WAIT_PEER;
                end
            end
            ST_WAIT_PEER: begin
                if (peer_ready) begin
                    state_d = ST_BUS;
                end
            end
            ST_BUS: begin
                if (mem_ack) begin
                    state_d = is_last ? ST_END : ST_WAIT_PEER;
                end
            end
            ST_END: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_req  = 1'b0;
        step     = 1'b0;
        done_set = 1'b0;
        busy     = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy     = 1'b0;
                done_set = go && cnt_zero;
            end
            ST_WAIT_PEER: begin
                mem_req = 1'b0;
            end
            ST_BUS: begin
                mem_req = 1'b1;
                step    = mem_ack;
            end
            ST_END: begin
                done_set = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/serdma_channel.sv
module serdma_channel
    import serdma_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int CNT_W    = 16,
    parameter int DATA_W   = 16,
    parameter int CHAN_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              peer_ready,
    input  logic [DATA_W-1:0] peer_rdata,
    output logic [DATA_W-1:0] peer_wdata,
    output logic              peer_strobe,
    output logic              xfer_word,
    output logic              busy,
    output logic              done,
    output logic              irq
);
    localparam int BYTE_W = DATA_W / 2;

    logic             load_addr;
    logic             load_cnt;
    logic             step;
    logic             use_word;
    logic             is_last;
    logic             cnt_zero;
    logic             go;
    logic             done_set;
    logic             irq_en;
    logic [CNT_W-1:0] cur_cnt;

    always_comb begin
        load_addr = cfg_we && (cfg_sel == SEL_ADDR)  && !busy;
        load_cnt  = cfg_we && (cfg_sel == SEL_COUNT) && !busy;
    end

    serdma_counters #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_addr (load_addr),
        .load_cnt  (load_cnt),
        .wdata     (cfg_wdata),
        .step      (step),
        .cur_addr  (mem_addr),
        .cur_cnt   (cur_cnt),
        .use_word  (use_word),
        .is_last   (is_last),
        .cnt_zero  (cnt_zero)
    );

    serdma_status stat_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .ctrl_bits (cfg_wdata[1:0]),
        .busy      (busy),
        .done_set  (done_set),
        .go        (go),
        .irq_en    (irq_en),
        .done      (done),
        .irq       (irq)
    );

    serdma_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .cnt_zero   (cnt_zero),
        .is_last    (is_last),
        .peer_ready (peer_ready),
        .mem_ack    (mem_ack),
        .mem_req    (mem_req),
        .step       (step),
        .done_set   (done_set),
        .busy       (busy)
    );

    // byte lanes: a byte rides on the low half, upper half zero
    always_comb begin
        mem_word    = use_word;
        xfer_word   = use_word;
        peer_strobe = step;
        mem_wdata   = use_word ? peer_rdata
                               : {{BYTE_W{1'b0}}, peer_rdata[BYTE_W-1:0]};
        peer_wdata  = use_word ? mem_rdata
                               : {{BYTE_W{1'b0}}, mem_rdata[BYTE_W-1:0]};
    end

    generate
        if ((CHAN_IDX % 2) == 0) begin : g_rx_dir
            assign mem_we = 1'b1;
        end else begin : g_tx_dir
            assign mem_we = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/serdma_chk.sv
module serdma_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_word,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              peer_ready,
    input logic              peer_strobe,
    input logic              busy,
    input logic              done,
    input logic              irq
);
    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_word));

    // R6
    peer_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(peer_ready));

    // R4
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_word |-> !mem_addr[0]);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R3
    strobe_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        peer_strobe |-> mem_req && mem_ack);

    // R7
    finish_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R8
    irq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);
endmodule

bind serdma_channel serdma_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req     (mem_req),
    .mem_ack     (mem_ack),
    .mem_word    (mem_word),
    .mem_addr    (mem_addr),
    .peer_ready  (peer_ready),
    .peer_strobe (peer_strobe),
    .busy        (busy),
    .done        (done),
    .irq         (irq)
);

// File: tb/serdma_channel_tb_top.sv
module serdma_channel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [23:0] cfg_wdata = '0;
    logic [15:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        peer_ready = 1'b0;
    logic [15:0] peer_rdata = '0;
    logic        dir = 1'b0;

    logic        rx_req, rx_we, rx_word, rx_strobe, rx_xw, rx_busy, rx_done, rx_irq;
    logic [23:0] rx_addr;
    logic [15:0] rx_wdata, rx_pw;
    logic        tx_req, tx_we, tx_word, tx_strobe, tx_xw, tx_busy, tx_done, tx_irq;
    logic [23:0] tx_addr;
    logic [15:0] tx_wdata, tx_pw;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int steps    = 0;
    int stall    = 0;
    logic [23:0] exp_a;
    int          exp_rem;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    serdma_channel #(.CHAN_IDX(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we && !dir), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .mem_req(rx_req), .mem_we(rx_we), .mem_word(rx_word),
        .mem_addr(rx_addr), .mem_wdata(rx_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .peer_ready(peer_ready), .peer_rdata(peer_rdata),
        .peer_wdata(rx_pw), .peer_strobe(rx_strobe), .xfer_word(rx_xw),
        .busy(rx_busy), .done(rx_done), .irq(rx_irq));

    serdma_channel #(.CHAN_IDX(1)) dut_tx_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we && dir), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .mem_req(tx_req), .mem_we(tx_we), .mem_word(tx_word),
        .mem_addr(tx_addr), .mem_wdata(tx_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .peer_ready(peer_ready), .peer_rdata(peer_rdata),
        .peer_wdata(tx_pw), .peer_strobe(tx_strobe), .xfer_word(tx_xw),
        .busy(tx_busy), .done(tx_done), .irq(tx_irq));

    wire        m_req    = dir ? tx_req    : rx_req;
    wire        m_we     = dir ? tx_we     : rx_we;
    wire        m_word   = dir ? tx_word   : rx_word;
    wire [23:0] m_addr   = dir ? tx_addr   : rx_addr;
    wire [15:0] m_wdata  = dir ? tx_wdata  : rx_wdata;
    wire [15:0] p_wdata  = dir ? tx_pw     : rx_pw;
    wire        p_strobe = dir ? tx_strobe : rx_strobe;
    wire        m_busy   = dir ? tx_busy   : rx_busy;
    wire        m_done   = dir ? tx_done   : rx_done;
    wire        m_irq    = dir ? tx_irq    : rx_irq;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    // serial readiness pattern and memory responder, driven at the falling edge
    always @(negedge clk) begin
        peer_ready = ((cyc % 5) != 2);
        peer_rdata = {8'hC0 ^ 8'(steps), 8'h30 + 8'(steps)};
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (m_req) begin
            if (stall != 0) begin
                stall--;
            end else begin
                logic ew;
                ew = !exp_a[0] && (exp_rem >= 2);
                check("R5 address", 32'(m_addr), 32'(exp_a));
                check("R4 width", 32'(m_word), 32'(ew));
                check("R3 direction", 32'(m_we), 32'(!dir));
                mem_rdata = {m_addr[7:0] ^ 8'h96, m_addr[7:0] + 8'h11};
                mem_ack = 1'b1;
                #1;
                check("R3 strobe", 32'(p_strobe), 32'd1);
                if (!dir)
                    check("R9 rx lanes", 32'(m_wdata), ew ? 32'(peer_rdata) : 32'(peer_rdata[7:0]));
                else
                    check("R9 tx lanes", 32'(p_wdata), ew ? 32'(mem_rdata) : 32'(mem_rdata[7:0]));
                exp_a   = exp_a + (ew ? 24'd2 : 24'd1);
                exp_rem = exp_rem - (ew ? 2 : 1);
                steps++;
                stall = (steps * 7) % 3;
            end
        end
    end

    task automatic cfg_write(input logic [1:0] sel, input logic [23:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic int steps_for(input logic [23:0] a, input int n);
        if (n == 0) return 0;
        if (a[0]) return 1 + (n - 1) / 2 + (n - 1) % 2;
        return n / 2 + n % 2;
    endfunction

    task automatic wait_idle();
        for (int i = 0; i < 400 && m_busy; i++) @(negedge clk);
    endtask

    task automatic run_xfer(input logic d, input logic [23:0] a, input int n, input logic ie);
        dir = d;
        cfg_write(2'd3, 24'd1);
        cfg_write(2'd0, a);
        cfg_write(2'd1, 24'(n));
        exp_a = a; exp_rem = n; steps = 0;
        cfg_write(2'd2, {22'd0, ie, 1'b1});
        wait_idle();
        @(negedge clk);
        check(n == 0 ? "R2 zero-count no access" : "R5 step count", 32'(steps), 32'(steps_for(a, n)));
        check("R7 count emptied", 32'(exp_rem), 32'd0);
        check("R7 idle", 32'(m_busy), 32'd0);
        check(n == 0 ? "R2 immediate done" : "R7 done", 32'(m_done), 32'd1);
        check("R8 irq gated", 32'(m_irq), 32'(ie));
        cfg_write(2'd3, 24'd1);
        check("R8 clear done", 32'(m_done), 32'd0);
        check("R8 irq low", 32'(m_irq), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 reset busy", 32'(rx_busy | tx_busy), 32'd0);
        check("R6 reset request", 32'(rx_req | tx_req), 32'd0);
        check("R8 reset done/irq", 32'({rx_done, rx_irq, tx_done, tx_irq}), 32'd0);

        for (int d = 0; d < 2; d++)
            for (int a = 0; a < 4; a++)
                for (int n = 0; n < 8; n++)
                    run_xfer(d[0], 24'h001230 + 24'(a), n, (a + n) % 2 == 1);

        // R5 address wrap at the top of the address space
        run_xfer(1'b1, 24'hFFFFFE, 5, 1'b1);
        check("R5 wrap", 32'(exp_a), 32'h000003);

        // R1 and R10: writes during a transfer are ignored
        dir = 1'b0;
        cfg_write(2'd3, 24'd1);
        cfg_write(2'd0, 24'h000100);
        cfg_write(2'd1, 24'd8);
        exp_a = 24'h000100; exp_rem = 8; steps = 0;
        cfg_write(2'd2, 24'd1);
        cfg_write(2'd0, 24'h000777);
        cfg_write(2'd1, 24'd3);
        cfg_write(2'd2, 24'd1);
        wait_idle();
        @(negedge clk);
        check("R1 busy writes ignored", 32'(steps), 32'd4);
        check("R10 go while busy ignored", 32'(exp_a), 32'h000108);
        check("R7 done after mid writes", 32'(m_done), 32'd1);
        finish_up();
    end
endmodule